// File: doc/BRIEF.md
# Masked Content-Addressable Memory with Priority Resolution

This block is a content-addressable memory of `ENTRIES` words, each `WIDTH` bits wide and each carrying its own validity bit. A search key (the comparand) is compared against every valid entry at once. A global mask selects which key bits are ignored. When several entries agree with the key, a priority encoder keeps the lowest-numbered one. The block reports that address joined with a static page number, along with hit and multiple-hit flags. It also tracks the lowest-numbered free (invalid) entry and raises a full flag once no free entry remains.

No separate command starts a search. Writing the comparand, the mask or the control bits runs a compare in the same cycle, using the value being written. A dedicated force input re-runs the compare with the current settings. The result lands in the status registers at the clock edge that samples the trigger. Writing an entry, which includes changing its validity, discards any earlier result, so a stale address is never reported. Two control bits gate the hit flags and the full flag independently.

Top module: `mcam_top`

## Requirements
- R1: A key bit whose mask bit is 1 is ignored in the compare against every entry. A key bit whose mask bit is 0 must equal the entry bit.
- R2: An entry whose validity bit is 0 never matches, whatever its data.
- R3: When several entries match, the match index is the lowest matching address. `st_multi` is 1 exactly when two or more entries match.
- R4: Each of the following triggers a compare: `cmp_wr_en`, `msk_wr_en`, `ctl_wr_en` or `force_cmp`. The compare uses the comparand, mask and control values being written in that cycle. It uses the entry contents as they were before any entry write in the same cycle. The status outputs change at the clock edge that samples the trigger.
- R5: `st_word` is `{page_id, idx}`, with `page_id` in the upper `PAGE_W` bits. `idx` is the match index, or 0 when nothing matched.
- R6: When the stored match-enable control bit is 0, `st_hit` and `st_multi` read 0. When the stored full-enable bit is 0, `st_full` reads 0.
- R7: `free_addr` is the lowest-numbered invalid entry and `free_vld` is 1. When every entry is valid, `free_vld` is 0 and `free_addr` is 0.
- R8: When full-enable is set, `st_full` is 1 exactly when every entry is valid. It follows an entry write at the edge that performs the write.
- R9: An entry write in a cycle without a compare trigger clears the hit, the multiple-hit and the match index to 0 at that edge.
- R10: In a cycle with neither a trigger nor an entry write, `st_word`, `st_hit` and `st_multi` keep their values.
- R11: After reset all entries are invalid. The comparand and mask are 0, both enable bits are 1 and the status is 0. `free_addr` is 0, `free_vld` is 1 and `st_full` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| page_id | input | PAGE_W | Static page number placed above the match index |
| wr_en | input | 1 | Entry write strobe |
| wr_addr | input | $clog2(ENTRIES) | Entry address to write |
| wr_data | input | WIDTH | Data stored into the entry |
| wr_valid | input | 1 | Validity bit stored with the entry (0 frees it) |
| cmp_wr_en | input | 1 | Load the comparand and run a compare |
| cmp_data | input | WIDTH | New comparand |
| msk_wr_en | input | 1 | Load the mask and run a compare |
| msk_data | input | WIDTH | New mask, 1 = ignore bit |
| ctl_wr_en | input | 1 | Load the control bits and run a compare |
| ctl_match_en | input | 1 | New match-flag enable |
| ctl_full_en | input | 1 | New full-flag enable |
| force_cmp | input | 1 | Run a compare with the current settings |
| st_word | output | PAGE_W+$clog2(ENTRIES) | Page number joined with the match index |
| st_hit | output | 1 | At least one valid entry matched |
| st_multi | output | 1 | Two or more valid entries matched |
| st_full | output | 1 | No invalid entry remains |
| free_addr | output | $clog2(ENTRIES) | Lowest invalid entry |
| free_vld | output | 1 | An invalid entry exists |

## Verification
The bound checker watches, on every cycle, the relations between the status outputs and their causes. A multiple hit never appears without a hit, and the page field always equals `page_id`. An entry write with no trigger clears the result, and the status holds still when nothing happens. A control write that disables matching hides the hit flags, and a full flag never coexists with a free entry. The directed scenarios are what show that the right entry wins: mask bits really become don't-cares, invalid entries are skipped, the lowest address has priority, and a compare in the same cycle as an entry write sees the old contents. Only these scenarios can show such results, because they depend on the stored data.

// File: rtl/mcam_pkg.sv
package mcam_pkg;

  // Stored control bits; both enables come up set after reset.
  typedef struct packed {
    logic match_en;
    logic full_en;
  } mcam_ctl_t;

  localparam mcam_ctl_t MCAM_CTL_RST = '{match_en: 1'b1, full_en: 1'b1};

endpackage

// File: rtl/mcam_store.sv
module mcam_store #(
  parameter int ENTRIES = 64,
  parameter int WIDTH   = 32,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [AW-1:0]                   wr_addr,
  input  logic [WIDTH-1:0]                wr_data,
  input  logic                            wr_valid,
  output logic [ENTRIES-1:0][WIDTH-1:0]   ent_data,
  output logic [ENTRIES-1:0]              ent_vld
);

  logic [ENTRIES-1:0] sel;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic             vld_d;
    logic             vld_q;
    logic [WIDTH-1:0] dat_q;

    assign sel[i] = wr_en && (wr_addr == AW'(i));

    always_comb begin
      vld_d = vld_q;
      if (sel[i]) vld_d = wr_valid;
    end

    // validity is reset, the data word is not
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (sel[i]) dat_q <= wr_data;
    end

    assign ent_data[i] = dat_q;
    assign ent_vld[i]  = vld_q;
  end

endmodule

// File: rtl/mcam_match.sv
module mcam_match #(
  parameter int ENTRIES = 64,
  parameter int WIDTH   = 32
) (
  input  logic [ENTRIES-1:0][WIDTH-1:0] ent_data,
  input  logic [ENTRIES-1:0]            ent_vld,
  input  logic [WIDTH-1:0]              key,
  input  logic [WIDTH-1:0]              mask,
  output logic [ENTRIES-1:0]            hit_vec
);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic [WIDTH-1:0] diff;
    assign diff       = (ent_data[i] ^ key) & ~mask;
    assign hit_vec[i] = ent_vld[i] && (diff == '0);
  end

endmodule

// File: rtl/mcam_prio.sv
module mcam_prio #(
  parameter int N   = 64,
  localparam int AW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [AW-1:0] idx,
  output logic          any,
  output logic          multi
);

  // scan from the top so the lowest set bit is the last one kept
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = i[AW-1:0];
    end
  end

  assign any   = |vec;
  assign multi = (vec & (vec - N'(1))) != '0;

endmodule

// File: rtl/mcam_top.sv
module mcam_top #(
  parameter int ENTRIES = 64,
  parameter int WIDTH   = 32,
  parameter int PAGE_W  = 8,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PAGE_W-1:0]    page_id,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [WIDTH-1:0]     wr_data,
  input  logic                 wr_valid,
  input  logic                 cmp_wr_en,
  input  logic [WIDTH-1:0]     cmp_data,
  input  logic                 msk_wr_en,
  input  logic [WIDTH-1:0]     msk_data,
  input  logic                 ctl_wr_en,
  input  logic                 ctl_match_en,
  input  logic                 ctl_full_en,
  input  logic                 force_cmp,
  output logic [PAGE_W+AW-1:0] st_word,
  output logic                 st_hit,
  output logic                 st_multi,
  output logic                 st_full,
  output logic [AW-1:0]        free_addr,
  output logic                 free_vld
);
  import mcam_pkg::*;

  // reset synchronizer: asserts at once, releases on the clock
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // entry array
  logic [ENTRIES-1:0][WIDTH-1:0] ent_data;
  logic [ENTRIES-1:0]            ent_vld;

  mcam_store #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) store_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_valid (wr_valid),
    .ent_data (ent_data),
    .ent_vld  (ent_vld)
  );

  // settings registers
  logic [WIDTH-1:0] key_q, key_d;
  logic [WIDTH-1:0] mask_q, mask_d;
  mcam_ctl_t        ctl_q, ctl_d;

  always_comb begin
    key_d  = key_q;
    mask_d = mask_q;
    ctl_d  = ctl_q;
    if (cmp_wr_en) key_d  = cmp_data;
    if (msk_wr_en) mask_d = msk_data;
    if (ctl_wr_en) begin
      ctl_d.match_en = ctl_match_en;
      ctl_d.full_en  = ctl_full_en;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      key_q  <= '0;
      mask_q <= '0;
      ctl_q  <= MCAM_CTL_RST;
    end else begin
      key_q  <= key_d;
      mask_q <= mask_d;
      ctl_q  <= ctl_d;
    end
  end

  // compare uses the settings being written this cycle
  logic [ENTRIES-1:0] hit_vec;

  mcam_match #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) match_i (
    .ent_data (ent_data),
    .ent_vld  (ent_vld),
    .key      (key_d),
    .mask     (mask_d),
    .hit_vec  (hit_vec)
  );

  logic [AW-1:0] m_idx;
  logic          m_any;
  logic          m_multi;

  mcam_prio #(.N(ENTRIES)) hit_prio_i (
    .vec   (hit_vec),
    .idx   (m_idx),
    .any   (m_any),
    .multi (m_multi)
  );

  // free-slot tracking
  logic          f_any;
  logic          f_multi;
  logic [AW-1:0] f_idx;

  mcam_prio #(.N(ENTRIES)) free_prio_i (
    .vec   (~ent_vld),
    .idx   (f_idx),
    .any   (f_any),
    .multi (f_multi)
  );

  // status registers
  logic          trig;
  logic          hit_q, hit_d;
  logic          multi_q, multi_d;
  logic [AW-1:0] idx_q, idx_d;

  assign trig = cmp_wr_en | msk_wr_en | ctl_wr_en | force_cmp;

  always_comb begin
    hit_d   = hit_q;
    multi_d = multi_q;
    idx_d   = idx_q;
    if (trig) begin
      hit_d   = m_any;
      multi_d = m_multi;
      idx_d   = m_idx;
    end else if (wr_en) begin
      hit_d   = 1'b0;
      multi_d = 1'b0;
      idx_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hit_q   <= 1'b0;
      multi_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      hit_q   <= hit_d;
      multi_q <= multi_d;
      idx_q   <= idx_d;
    end
  end

  assign st_word   = {page_id, idx_q};
  assign st_hit    = hit_q & ctl_q.match_en;
  assign st_multi  = multi_q & ctl_q.match_en;
  assign st_full   = ctl_q.full_en & ~f_any;
  assign free_addr = f_idx;
  assign free_vld  = f_any;

endmodule

// File: rtl/mcam_chk.sv
module mcam_chk #(
  parameter int PAGE_W = 8,
  parameter int AW     = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [PAGE_W-1:0]    page_id,
  input logic                 wr_en,
  input logic                 cmp_wr_en,
  input logic                 msk_wr_en,
  input logic                 ctl_wr_en,
  input logic                 ctl_match_en,
  input logic                 force_cmp,
  input logic [PAGE_W+AW-1:0] st_word,
  input logic                 st_hit,
  input logic                 st_multi,
  input logic                 st_full,
  input logic [AW-1:0]        free_addr,
  input logic                 free_vld
);

  logic any_trig;
  assign any_trig = cmp_wr_en | msk_wr_en | ctl_wr_en | force_cmp;

  // R3
  multi_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_multi |-> st_hit);

  // R5
  page_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_word[PAGE_W+AW-1:AW] == page_id);

  // R9
  write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !any_trig) |=> (!st_hit && !st_multi && st_word[AW-1:0] == '0));

  // R10
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !any_trig) |=> ($stable(st_word[AW-1:0]) && $stable(st_hit) && $stable(st_multi)));

  // R6
  match_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_en && !ctl_match_en) |=> (!st_hit && !st_multi));

  // R8
  full_excl_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_full |-> !free_vld);

  // R7
  no_free_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !free_vld |-> (free_addr == '0));

endmodule

bind mcam_top mcam_chk #(.PAGE_W(PAGE_W), .AW(AW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .page_id      (page_id),
  .wr_en        (wr_en),
  .cmp_wr_en    (cmp_wr_en),
  .msk_wr_en    (msk_wr_en),
  .ctl_wr_en    (ctl_wr_en),
  .ctl_match_en (ctl_match_en),
  .force_cmp    (force_cmp),
  .st_word      (st_word),
  .st_hit       (st_hit),
  .st_multi     (st_multi),
  .st_full      (st_full),
  .free_addr    (free_addr),
  .free_vld     (free_vld)
);

// File: tb/mcam_top_tb_top.sv
module mcam_top_tb_top;
  localparam int N  = 8;
  localparam int W  = 8;
  localparam int PW = 4;
  localparam int AW = $clog2(N);
  localparam logic [PW-1:0] PAGE = 4'hA;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, wr_valid, cmp_wr_en, msk_wr_en, ctl_wr_en;
  logic          ctl_match_en, ctl_full_en, force_cmp;
  logic [AW-1:0] wr_addr;
  logic [W-1:0]  wr_data, cmp_data, msk_data;
  logic [PW+AW-1:0] st_word;
  logic          st_hit, st_multi, st_full, free_vld;
  logic [AW-1:0] free_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  mcam_top #(.ENTRIES(N), .WIDTH(W), .PAGE_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .page_id(PAGE),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_valid(wr_valid),
    .cmp_wr_en(cmp_wr_en), .cmp_data(cmp_data),
    .msk_wr_en(msk_wr_en), .msk_data(msk_data),
    .ctl_wr_en(ctl_wr_en), .ctl_match_en(ctl_match_en), .ctl_full_en(ctl_full_en),
    .force_cmp(force_cmp),
    .st_word(st_word), .st_hit(st_hit), .st_multi(st_multi), .st_full(st_full),
    .free_addr(free_addr), .free_vld(free_vld)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_status(string req, int idx, bit hit, bit multi);
    chk({req, " word"}, int'(st_word), int'({PAGE, AW'(idx)}));
    chk({req, " hit"}, int'(st_hit), int'(hit));
    chk({req, " multi"}, int'(st_multi), int'(multi));
  endtask

  task automatic idle_inputs();
    wr_en = 0; wr_valid = 0; wr_addr = '0; wr_data = '0;
    cmp_wr_en = 0; cmp_data = '0; msk_wr_en = 0; msk_data = '0;
    ctl_wr_en = 0; ctl_match_en = 0; ctl_full_en = 0; force_cmp = 0;
  endtask

  // drive away from the edge, return just after the sampling edge
  task automatic step();
    @(posedge clk);
    #1;
    idle_inputs();
  endtask

  task automatic put(int a, int d, bit v);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(a); wr_data = W'(d); wr_valid = v;
    step();
  endtask

  task automatic set_key(int d);
    @(negedge clk); cmp_wr_en = 1; cmp_data = W'(d); step();
  endtask

  task automatic set_mask(int d);
    @(negedge clk); msk_wr_en = 1; msk_data = W'(d); step();
  endtask

  task automatic set_ctl(bit m, bit f);
    @(negedge clk); ctl_wr_en = 1; ctl_match_en = m; ctl_full_en = f; step();
  endtask

  task automatic t_reset();
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    chk_status("R11 reset", 0, 0, 0);
    chk("R11 free_addr", int'(free_addr), 0);
    chk("R11 free_vld", int'(free_vld), 1);
    chk("R11 full", int'(st_full), 0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < N; i++) begin
      put(i, 'h10 + i, 1);
      if (i < N - 1) begin
        chk("R7 free_addr", int'(free_addr), i + 1);
        chk("R8 not full", int'(st_full), 0);
      end
    end
    chk("R7 no free", int'(free_vld), 0);
    chk("R7 free_addr zero", int'(free_addr), 0);
    chk("R8 full", int'(st_full), 1);
  endtask

  task automatic t_basic();
    set_key('h13);  // R4 comparand write triggers
    chk_status("R1 R4 exact key", 3, 1, 0);
  endtask

  task automatic t_ctl();
    set_ctl(0, 0);
    chk_status("R6 match off", 3, 0, 0);
    chk("R6 full off", int'(st_full), 0);
    set_ctl(1, 1);
    chk_status("R6 R4 ctl retrigger", 3, 1, 0);
    chk("R6 full on", int'(st_full), 1);
  endtask

  task automatic t_invalidate();
    put(5, 'h15, 0);
    chk_status("R9 write clears", 0, 0, 0);
    chk("R7 freed slot", int'(free_addr), 5);
    chk("R8 not full after free", int'(st_full), 0);
    set_key('h15);
    chk_status("R2 invalid skipped", 0, 0, 0);
  endtask

  task automatic t_mask();
    set_mask('h01);  // 0x14 qualifies, 0x15 invalid
    chk_status("R1 R4 mask one bit", 4, 1, 0);
    set_mask('h03);  // 0x14, 0x16, 0x17 qualify
    chk_status("R3 lowest wins", 4, 1, 1);
    repeat (3) @(negedge clk);
    chk_status("R10 idle hold", 4, 1, 1);
  endtask

  task automatic t_same_cycle();
    set_mask('h00);
    chk_status("R2 mask cleared", 0, 0, 0);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(2); wr_data = W'('h99); wr_valid = 1;
    cmp_wr_en = 1; cmp_data = W'('h99);
    step();
    chk_status("R4 old contents", 0, 0, 0);
    @(negedge clk); force_cmp = 1; step();
    chk_status("R4 force compare", 2, 1, 0);
  endtask

  initial begin
    t_reset();
    t_fill();
    t_basic();
    t_ctl();
    t_invalidate();
    t_mask();
    t_same_cycle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1..all: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule